// File: doc/BRIEF.md
# Multi-Beam Weighted-Sum Beamformer

This block forms several beams from channelized array data. Each input transfer carries one complex sample for every array element, all for a single frequency bin. For each beam, the block multiplies every element sample by the complex conjugate of a weight and sums the products across all elements. The weight is chosen by frequency bin, element and beam. Because a weight is complex, it can correct both the gain and the phase of its element path. Each bin is therefore steered independently.

Input vectors arrive in a fixed order: bins ascending within a time sample, and time samples ascending within a frame. For each accepted vector, the block emits one full-precision complex result per beam, in beam order, over a valid/ready output.

Weights are written by a host into an inactive copy of the table. A commit request makes that copy live at the next frame boundary, so a frame is never computed with a mix of old and new weights. `N_BIN` and `N_BEAM` must be powers of two.

Top module: `bf_weighted_sum`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `out_valid` is 0 and `in_ready` is 1. The live weight table after reset is the one that host writes do not reach.
- R2: Element e of `in_data` has its real part at bits [16e+7:16e] and its imaginary part at bits [16e+15:16e+8], both 8-bit two's complement. With weight parts wr (from `wt_re`) and wi (from `wt_im`), the beam result is `out_re` = Σ(wr·xr + wi·xi) and `out_im` = Σ(wr·xi − wi·xr), summed over all elements.
- R3: The result is exact at full scale; nothing is truncated or saturated. All parts at −128 give 262144 + 0j. Weights at −128 with every input at 127 − 128j give 1024 + 261120j.
- R4: The n-th vector accepted since reset is bin n mod `N_BIN` and time sample ⌊n/`N_BIN`⌋ mod `N_TIME`. It uses the weights stored for that bin, and `out_bin`/`out_t` report that bin and time sample with each of its results.
- R5: Each accepted vector produces exactly `N_BEAM` results, with `out_beam` counting 0, 1, … in order. Each result uses that beam's weights.
- R6: While `out_valid` is 1 and `out_ready` is 0, all outputs hold steady. With `in_valid` low and nothing in flight, `out_valid` stays 0.
- R7: `in_ready` is 1 when no vector is in flight, or when the last beam is being transferred in this cycle. A vector accepted at one edge is presented as beam 0 after that edge. After the last beam is taken with no new input, `out_valid` falls.
- R8: A host write (`wt_we`, addressed by `wt_bin`, `wt_elem`, `wt_beam`) changes only the inactive table. It has no effect on any result until that table becomes live.
- R9: A pulse on `wt_commit` swaps the live and inactive tables at the next frame boundary, where a frame is `N_BIN`·`N_TIME` vectors. If the block is idle at a frame start, the swap happens on the following cycle. After a swap, the old live table becomes the write target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Block can accept a vector |
| in_data | input | N_ELEM·2·SW | Complex samples for all elements, one bin |
| wt_we | input | 1 | Weight write strobe |
| wt_bin | input | log2 N_BIN | Weight bin address |
| wt_elem | input | log2 N_ELEM | Weight element address |
| wt_beam | input | log2 N_BEAM | Weight beam address |
| wt_re | input | WW | Weight real part |
| wt_im | input | WW | Weight imaginary part (stored unconjugated) |
| wt_commit | input | 1 | Request table swap at next frame boundary |
| out_valid | output | 1 | Beam result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_beam | output | log2 N_BEAM | Beam index of result |
| out_bin | output | log2 N_BIN | Bin of result |
| out_t | output | log2 N_TIME | Time sample of result |
| out_re | output | SW+WW+2+log2 N_ELEM | Beam real part, signed |
| out_im | output | SW+WW+2+log2 N_ELEM | Beam imaginary part, signed |

## Verification
The properties assume that `rst_n` starts low and that the consumer obeys the output handshake. They also assume that the host never issues `wt_commit` in the same cycle that a frame-start vector is accepted.

The directed stimulus sends one vector at a time and drives every input on the falling edge. It issues commits only between vectors. After an idle commit, it waits one extra cycle before writing again, so that the swap has settled before the next write.

// File: rtl/bf_weighted_sum.sv
module bf_weighted_sum #(
  parameter int N_ELEM = 8,
  parameter int N_BIN  = 64,
  parameter int N_TIME = 8,
  parameter int N_BEAM = 2,
  parameter int SW     = 8,
  parameter int WW     = 8,
  localparam int ELEM_W = $clog2(N_ELEM),
  localparam int BIN_W  = $clog2(N_BIN),
  localparam int T_W    = $clog2(N_TIME),
  localparam int BEAM_W = $clog2(N_BEAM),
  localparam int ACC_W  = SW + WW + 2 + ELEM_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [N_ELEM*2*SW-1:0]   in_data,
  input  logic                     wt_we,
  input  logic [BIN_W-1:0]         wt_bin,
  input  logic [ELEM_W-1:0]        wt_elem,
  input  logic [BEAM_W-1:0]        wt_beam,
  input  logic [WW-1:0]            wt_re,
  input  logic [WW-1:0]            wt_im,
  input  logic                     wt_commit,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [BEAM_W-1:0]        out_beam,
  output logic [BIN_W-1:0]         out_bin,
  output logic [T_W-1:0]           out_t,
  output logic signed [ACC_W-1:0]  out_re,
  output logic signed [ACC_W-1:0]  out_im
);
  localparam int AW = 1 + BIN_W + BEAM_W;
  localparam int PW = SW + WW + 2;

  logic                   busy, bank, pend;
  logic [BEAM_W-1:0]      beam;
  logic [BIN_W-1:0]       cur_bin, nxt_bin;
  logic [T_W-1:0]         cur_t, nxt_t;
  logic [N_ELEM*2*SW-1:0] hold;
  logic [2*WW-1:0]        wsel [N_ELEM];
  logic signed [PW-1:0]   p_re [N_ELEM];
  logic signed [PW-1:0]   p_im [N_ELEM];
  logic signed [ACC_W-1:0] acc_re, acc_im;

  wire last  = (beam == BEAM_W'(N_BEAM - 1));
  wire fire  = busy & out_ready;
  wire take  = in_valid & in_ready;
  wire start = (nxt_bin == '0) && (nxt_t == '0);
  wire swap  = pend & start & (~busy | (fire & last));
  wire [AW-1:0] raddr = {bank, cur_bin, beam};
  wire [AW-1:0] waddr = {~bank, wt_bin, wt_beam};

  assign in_ready  = ~busy | (fire & last);
  assign out_valid = busy;
  assign out_beam  = beam;
  assign out_bin   = cur_bin;
  assign out_t     = cur_t;
  assign out_re    = acc_re;
  assign out_im    = acc_im;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      beam    <= '0;
      cur_bin <= '0;
      cur_t   <= '0;
      nxt_bin <= '0;
      nxt_t   <= '0;
      hold    <= '0;
      bank    <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (take) begin
        busy    <= 1'b1;
        beam    <= '0;
        hold    <= in_data;
        cur_bin <= nxt_bin;
        cur_t   <= nxt_t;
        if (nxt_bin == BIN_W'(N_BIN - 1)) begin
          nxt_bin <= '0;
          nxt_t   <= (nxt_t == T_W'(N_TIME - 1)) ? '0 : nxt_t + 1'b1;
        end else begin
          nxt_bin <= nxt_bin + 1'b1;
        end
      end else if (fire) begin
        if (last) busy <= 1'b0;
        else      beam <= beam + 1'b1;
      end
      if (swap) bank <= ~bank;
      pend <= wt_commit | (pend & ~swap);
    end
  end

  for (genvar e = 0; e < N_ELEM; e++) begin : g_el
    logic [2*WW-1:0]     mem [2**AW];
    logic signed [SW-1:0] xr, xi;
    logic signed [WW:0]   wr, wn;

    always_ff @(posedge clk)
      if (wt_we && wt_elem == ELEM_W'(e)) mem[waddr] <= {wt_im, wt_re};

    assign wsel[e] = mem[raddr];
    assign xr = $signed(hold[e*2*SW +: SW]);
    assign xi = $signed(hold[e*2*SW+SW +: SW]);
    assign wr = $signed({wsel[e][WW-1], wsel[e][WW-1:0]});
    assign wn = -$signed({wsel[e][2*WW-1], wsel[e][2*WW-1:WW]});
    assign p_re[e] = wr * xr - wn * xi;
    assign p_im[e] = wr * xi + wn * xr;
  end

  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int e = 0; e < N_ELEM; e++) begin
      acc_re = acc_re + ACC_W'(p_re[e]);
      acc_im = acc_im + ACC_W'(p_im[e]);
    end
  end
endmodule

// File: rtl/bf_weighted_sum_chk.sv
module bf_weighted_sum_chk #(
  parameter int N_BEAM = 2,
  parameter int BEAM_W = 1,
  parameter int BIN_W  = 6,
  parameter int T_W    = 3,
  parameter int ACC_W  = 21
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [BEAM_W-1:0]       out_beam,
  input logic [BIN_W-1:0]        out_bin,
  input logic [T_W-1:0]          out_t,
  input logic signed [ACC_W-1:0] out_re,
  input logic signed [ACC_W-1:0] out_im
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_beam) && $stable(out_bin)
      && $stable(out_t) && $stable(out_re) && $stable(out_im));

  a_r5_beam_step: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_beam != BEAM_W'(N_BEAM - 1)
      |=> out_valid && out_beam == $past(out_beam) + 1'b1 && $stable(out_bin) && $stable(out_t));

  a_r7_first_beam: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_beam == '0);

  a_r7_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_beam == BEAM_W'(N_BEAM - 1) && !in_valid |=> !out_valid);
endmodule

bind bf_weighted_sum bf_weighted_sum_chk #(
  .N_BEAM(N_BEAM), .BEAM_W(BEAM_W), .BIN_W(BIN_W), .T_W(T_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_beam(out_beam),
  .out_bin(out_bin), .out_t(out_t), .out_re(out_re), .out_im(out_im)
);

// File: tb/sim_bf_weighted_sum.sv
module sim_bf_weighted_sum;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8, NB = 4, NT = 2, NBM = 2;
  localparam int FR = NB * NT;
  localparam int ACC = 8 + 8 + 2 + 3;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [NE*16-1:0] in_data = '0;
  logic wt_we = 0, wt_commit = 0;
  logic [1:0] wt_bin = '0;
  logic [2:0] wt_elem = '0;
  logic [0:0] wt_beam = '0;
  logic [7:0] wt_re = '0, wt_im = '0;
  logic out_valid, out_ready = 1;
  logic [0:0] out_beam;
  logic [1:0] out_bin;
  logic [0:0] out_t;
  logic signed [ACC-1:0] out_re, out_im;

  int checks = 0, errors = 0;
  int idx = 0, act_m = 0, pend_m = 0;
  int wre_m [2][NB][NE][NBM];
  int wim_m [2][NB][NE][NBM];
  int xr_c [NE];
  int xi_c [NE];

  always #(CLK_PERIOD/2) clk = ~clk;

  bf_weighted_sum #(.N_ELEM(NE), .N_BIN(NB), .N_TIME(NT), .N_BEAM(NBM)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .wt_we(wt_we), .wt_bin(wt_bin), .wt_elem(wt_elem), .wt_beam(wt_beam),
    .wt_re(wt_re), .wt_im(wt_im), .wt_commit(wt_commit),
    .out_valid(out_valid), .out_ready(out_ready), .out_beam(out_beam),
    .out_bin(out_bin), .out_t(out_t), .out_re(out_re), .out_im(out_im));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wval(int s, int bin, int e, int b, int k);
    return ((s*53 + bin*29 + e*17 + b*71 + k*101) % 256) - 128;
  endfunction

  function automatic longint exp_re(int bin, int b);
    longint s = 0;
    for (int e = 0; e < NE; e++)
      s += wre_m[act_m][bin][e][b]*xr_c[e] + wim_m[act_m][bin][e][b]*xi_c[e];
    return s;
  endfunction

  function automatic longint exp_im(int bin, int b);
    longint s = 0;
    for (int e = 0; e < NE; e++)
      s += wre_m[act_m][bin][e][b]*xi_c[e] - wim_m[act_m][bin][e][b]*xr_c[e];
    return s;
  endfunction

  task automatic load_table(input int seed, input bit minval);
    for (int bn = 0; bn < NB; bn++)
      for (int e = 0; e < NE; e++)
        for (int b = 0; b < NBM; b++) begin
          int r = minval ? -128 : wval(seed, bn, e, b, 0);
          int i = minval ? -128 : wval(seed, bn, e, b, 1);
          @(negedge clk);
          wt_we = 1; wt_bin = 2'(bn); wt_elem = 3'(e); wt_beam = 1'(b);
          wt_re = 8'(r); wt_im = 8'(i);
          wre_m[act_m ^ 1][bn][e][b] = r;
          wim_m[act_m ^ 1][bn][e][b] = i;
        end
    @(negedge clk) wt_we = 0;
  endtask

  task automatic commit();
    @(negedge clk) wt_commit = 1;
    @(negedge clk) wt_commit = 0;
    @(negedge clk);
    pend_m = 1;
    if (idx % FR == 0) begin act_m ^= 1; pend_m = 0; end
  endtask

  task automatic set_x(input int mode, input int seed);
    for (int e = 0; e < NE; e++) begin
      case (mode)
        1: begin xr_c[e] = -128; xi_c[e] = -128; end
        2: begin xr_c[e] = 127;  xi_c[e] = -128; end
        default: begin
          xr_c[e] = ((idx*13 + e*7 + seed) % 256) - 128;
          xi_c[e] = ((idx*31 + e*19 + seed*3) % 256) - 128;
        end
      endcase
    end
  endtask

  task automatic send_vec(input bit stall, input string tag);
    int bin = idx % NB;
    int t = (idx / NB) % NT;
    logic signed [ACC-1:0] sr, si;
    if (idx % FR == 0 && pend_m != 0) begin act_m ^= 1; pend_m = 0; end
    @(negedge clk);
    chk(in_ready == 1, "R7", in_ready, 1);
    in_valid = 1;
    for (int e = 0; e < NE; e++) begin
      in_data[e*16 +: 8] = 8'(xr_c[e]);
      in_data[e*16+8 +: 8] = 8'(xi_c[e]);
    end
    @(negedge clk) in_valid = 0;
    for (int b = 0; b < NBM; b++) begin
      if (stall && b == 0) begin
        out_ready = 0; sr = out_re; si = out_im;
        repeat (2) @(negedge clk);
        chk(out_valid && out_beam == 0 && out_re == sr && out_im == si, "R6",
            longint'(out_re), longint'(sr));
        out_ready = 1;
      end
      chk(out_valid == 1, "R7", out_valid, 1);
      chk(out_beam == 1'(b), "R5", out_beam, b);
      chk(out_bin == 2'(bin) && out_t == 1'(t), "R4", out_bin, bin);
      chk(longint'(out_re) == exp_re(bin, b), tag, longint'(out_re), exp_re(bin, b));
      chk(longint'(out_im) == exp_im(bin, b), tag, longint'(out_im), exp_im(bin, b));
      chk(in_ready == (b == NBM-1), "R7", in_ready, (b == NBM-1));
      @(negedge clk);
    end
    chk(out_valid == 0, "R7", out_valid, 0);
    idx++;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && in_ready == 1, "R1", {out_valid, in_ready}, 1);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && in_ready == 1, "R1", {out_valid, in_ready}, 1);
  endtask

  task automatic t_basic();
    load_table(1, 0);
    commit();
    for (int v = 0; v < FR; v++) begin
      set_x(0, 5);
      send_vec(v == 2, "R2");
    end
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && in_ready == 1, "R6", out_valid, 0);
  endtask

  task automatic t_extreme();
    load_table(0, 1);
    commit();
    for (int v = 0; v < FR; v++) begin
      set_x(v % 3 == 0 ? 1 : (v % 3 == 1 ? 2 : 0), 9);
      send_vec(0, "R3");
    end
  endtask

  task automatic t_shadow();
    load_table(2, 0);
    commit();
    for (int v = 0; v < 3; v++) begin set_x(0, 11); send_vec(0, "R9"); end
    load_table(3, 0);
    commit();
    for (int v = 0; v < 5; v++) begin set_x(0, 12); send_vec(v == 1, "R8"); end
    for (int v = 0; v < 2; v++) begin set_x(0, 13); send_vec(0, "R9"); end
  endtask

  task automatic t_idle_commit();
    while (idx % FR != 0) begin set_x(0, 14); send_vec(0, "R2"); end
    load_table(4, 0);
    commit();
    load_table(5, 0);
    for (int v = 0; v < 2; v++) begin set_x(0, 15); send_vec(0, "R9"); end
    set_x(0, 16); send_vec(0, "R8");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_extreme();
    t_shadow();
    t_idle_commit();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule